// File: doc/BRIEF.md
# Page Translation With Fault Checking

This block turns a virtual address into a physical address using a single-level page table held inside the block. The upper bits of the virtual address select one entry of the table. The lower bits pass through unchanged as the byte offset within the page. Before it returns a physical address, the block runs a fixed sequence of checks on the entry. If any check fails, it returns a fault code, and only the highest-priority failure is reported.

The block holds several independent tables, one for each address space. A privileged select register picks the table that later lookups use, and software reloads it when it switches from one process to another. A privileged write port fills in table entries. The block never services a fault: a not-resident page is reported, and the requester handles it.

A request is accepted when `req_valid` and `req_ready` are both high on a rising edge. The response is presented for exactly one cycle, on the following cycle. A new request can be accepted on the cycle after that.

Top module: `page_xlate`

## Requirements
- R1: After reset, `rsp_valid` is low, `req_ready` is high, the table select is 0, and every entry of every table reads as absent.
- R2: A request accepted at a rising edge produces `rsp_valid` high for exactly the next cycle. During that cycle `req_ready` is low.
- R3: A successful lookup returns `rsp_fault` = 0 and `rsp_pa` = {frame number from the entry, `req_va[11:0]`}.
- R4: An entry whose exists bit (`tbl_data[8]`) is clear gives fault code 1.
- R5: An entry that exists but whose mapped bit (`tbl_data[9]`) is clear gives fault code 2.
- R6: The access type is encoded in `req_acc` as 0 = read, 1 = write and 2 = execute; value 3 is always refused. The permission bits are read `tbl_data[10]`, write `tbl_data[11]` and execute `tbl_data[12]`. If the bit for the requested access is clear, the result is fault code 3. If the kernel-only bit (`tbl_data[13]`) is set while `req_kmode` = 0, the result is also fault code 3. Kernel mode may use kernel-only pages.
- R7: An entry that exists, is mapped and is permitted, but whose resident bit (`tbl_data[14]`) is clear, gives fault code 4.
- R8: When several checks fail, only the first failing check in the order exists, mapped, permission, resident is reported. The fault code never exceeds 4.
- R9: A pulse on `base_we` loads `base_set`. Lookups accepted after that edge use the selected table. Table writes go to the table named by `tbl_set`, whatever the current selection.
- R10: A table write presented in the same cycle that a request is accepted is dropped. The accepted lookup and all later lookups see the old entry.
- R11: Whenever `rsp_fault` is not 0, `rsp_pa` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 16 | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| req_kmode | input | 1 | 1 = kernel mode, 0 = user mode |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_pa | output | 20 | Physical address, 0 on a fault |
| rsp_fault | output | 3 | 0 ok, 1 no entry, 2 unmapped, 3 protection, 4 page fault |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_set | input | 1 | Table written |
| tbl_vpn | input | 4 | Page index written |
| tbl_data | input | 15 | Entry: [7:0] frame, [8] exists, [9] mapped, [10] read, [11] write, [12] execute, [13] kernel-only, [14] resident |
| base_we | input | 1 | Table select load strobe |
| base_set | input | 1 | Table select value |

## Verification
The bench translates addresses whose entries fail exactly one check, each in turn. This shows that every fault code is produced by its own cause. It then uses entries that fail several checks at once. These show that the reported code follows the priority order and not some other order. Access types are varied against single permission bits, and both modes are used on kernel-only pages. This separates a missing permission bit from a mode restriction. The same page index is then looked up in two tables, and a write is made to collide with an accepted request. These show that the select register is honoured and that the write is dropped.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W      = 16,
  parameter int PAGE_BITS = 12,
  parameter int PFN_W     = 8,
  parameter int NSETS     = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_va,
  input  logic [1:0]             req_acc,
  input  logic                   req_kmode,
  output logic                   rsp_valid,
  output logic [PFN_W+PAGE_BITS-1:0] rsp_pa,
  output logic [2:0]             rsp_fault,
  input  logic                   tbl_we,
  input  logic [(NSETS>1?$clog2(NSETS):1)-1:0] tbl_set,
  input  logic [VA_W-PAGE_BITS-1:0] tbl_vpn,
  input  logic [PFN_W+6:0]       tbl_data,
  input  logic                   base_we,
  input  logic [(NSETS>1?$clog2(NSETS):1)-1:0] base_set
);
  localparam int VPN_W  = VA_W - PAGE_BITS;
  localparam int NPAGES = 1 << VPN_W;
  localparam int SET_W  = NSETS > 1 ? $clog2(NSETS) : 1;
  localparam int ENT_W  = PFN_W + 7;
  localparam int IDX_W  = SET_W + VPN_W;
  localparam int NENT   = NPAGES << SET_W;
  localparam int PA_W   = PFN_W + PAGE_BITS;
  localparam int B_EX   = PFN_W;
  localparam int B_MAP  = PFN_W + 1;
  localparam int B_RD   = PFN_W + 2;
  localparam int B_WR   = PFN_W + 3;
  localparam int B_XE   = PFN_W + 4;
  localparam int B_KO   = PFN_W + 5;
  localparam int B_RES  = PFN_W + 6;

  logic [ENT_W-1:0] tbl [NENT];
  logic [SET_W-1:0] cur_set;
  logic             accept;
  logic [ENT_W-1:0] ent;
  logic             acc_ok;
  logic [2:0]       code;

  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign ent       = tbl[{cur_set, req_va[VA_W-1:PAGE_BITS]}];

  always_comb begin
    case (req_acc)
      2'd0:    acc_ok = ent[B_RD];
      2'd1:    acc_ok = ent[B_WR];
      2'd2:    acc_ok = ent[B_XE];
      default: acc_ok = 1'b0;
    endcase
    if (ent[B_KO] && !req_kmode) acc_ok = 1'b0;
  end

  always_comb begin
    if (!ent[B_EX])        code = 3'd1;
    else if (!ent[B_MAP])  code = 3'd2;
    else if (!acc_ok)      code = 3'd3;
    else if (!ent[B_RES])  code = 3'd4;
    else                   code = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) tbl[i] <= '0;
    end else if (tbl_we && !accept) begin
      tbl[{tbl_set, tbl_vpn}] <= tbl_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_set   <= '0;
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= '0;
    end else begin
      if (base_we) cur_set <= base_set;
      rsp_valid <= accept;
      if (accept) begin
        rsp_fault <= code;
        rsp_pa    <= (code == 3'd0) ? {ent[PFN_W-1:0], req_va[PAGE_BITS-1:0]} : '0;
      end
    end
  end
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int VA_W      = 16,
  parameter int PAGE_BITS = 12,
  parameter int PA_W      = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_va,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_pa,
  input logic [2:0]      rsp_fault
);
  assert_rsp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  assert_rsp_only_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);
  assert_busy_during_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  assert_code_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault <= 3'd4);
  assert_fault_zero_pa_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> rsp_pa == '0);
  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (rsp_fault != 3'd0 || rsp_pa[PAGE_BITS-1:0] == $past(req_va[PAGE_BITS-1:0])));
endmodule

bind page_xlate page_xlate_chk #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault));

// File: tb/page_xlate_tb.sv
module page_xlate_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_kmode = 0, tbl_we = 0, base_we = 0;
  logic [15:0] req_va = 0;
  logic [1:0]  req_acc = 0;
  logic [0:0]  tbl_set = 0, base_set = 0;
  logic [3:0]  tbl_vpn = 0;
  logic [14:0] tbl_data = 0;
  logic        req_ready, rsp_valid;
  logic [19:0] rsp_pa;
  logic [2:0]  rsp_fault;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate u_dut (.*);

  function automatic logic [14:0] ent(input logic [7:0] pfn, input logic ex, mp, rd, wr, xe, ko, res);
    return {res, ko, xe, wr, rd, mp, ex, pfn};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ent(input logic s, input logic [3:0] v, input logic [14:0] d);
    @(negedge clk); tbl_we = 1; tbl_set = s; tbl_vpn = v; tbl_data = d;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic sel(input logic s);
    @(negedge clk); base_we = 1; base_set = s;
    @(negedge clk); base_we = 0;
  endtask

  task automatic xl(input string tag, input logic [15:0] va, input logic [1:0] acc,
                    input logic km, input logic [2:0] efault, input logic [19:0] epa);
    @(negedge clk); req_valid = 1; req_va = va; req_acc = acc; req_kmode = km;
    @(negedge clk); req_valid = 0;
    chk({tag, " valid"}, rsp_valid, 1);
    chk({tag, " ready low"}, req_ready, 0);
    chk({tag, " fault"}, rsp_fault, efault);
    chk({tag, " pa"}, rsp_pa, epa);
    @(negedge clk);
    chk({tag, " single pulse"}, rsp_valid, 0);
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 ready", req_ready, 1);
    xl("R1 empty table", 16'h3abc, 0, 1, 1, 0);
  endtask

  task automatic t_ok;
    wr_ent(0, 4'h2, ent(8'h5a, 1,1,1,1,1,0,1));
    xl("R3 read", 16'h2123, 0, 0, 0, 20'h5a123);
    xl("R3 write", 16'h2fff, 1, 0, 0, 20'h5afff);
    xl("R3 exec", 16'h2000, 2, 1, 0, 20'h5a000);
  endtask

  task automatic t_single_faults;
    xl("R4 no entry", 16'h7010, 0, 1, 1, 0);
    wr_ent(0, 4'h0, ent(8'h11, 1,0,1,1,1,0,1));
    xl("R5 null page unmapped", 16'h0004, 0, 1, 2, 0);
    wr_ent(0, 4'h3, ent(8'h22, 1,1,1,0,0,0,1));
    xl("R6 write to read-only", 16'h3100, 1, 1, 3, 0);
    xl("R6 exec without x", 16'h3100, 2, 1, 3, 0);
    xl("R6 reserved acc", 16'h3100, 3, 1, 3, 0);
    xl("R6 read ok", 16'h3100, 0, 0, 0, 20'h22100);
    wr_ent(0, 4'h4, ent(8'h33, 1,1,1,1,0,1,1));
    xl("R6 user on kernel page", 16'h4008, 0, 0, 3, 0);
    xl("R6 kernel on kernel page", 16'h4008, 1, 1, 0, 20'h33008);
    wr_ent(0, 4'h6, ent(8'h44, 1,1,1,1,1,0,0));
    xl("R7 not resident", 16'h6abc, 0, 0, 4, 0);
  endtask

  task automatic t_priority;
    wr_ent(0, 4'h8, ent(8'h00, 0,0,0,0,0,1,0));
    xl("R8 absent beats all", 16'h8000, 1, 0, 1, 0);
    wr_ent(0, 4'h9, ent(8'h00, 1,0,0,0,0,1,0));
    xl("R8 unmapped beats perm", 16'h9000, 1, 0, 2, 0);
    wr_ent(0, 4'ha, ent(8'h77, 1,1,0,0,0,0,0));
    xl("R8 perm beats resident", 16'ha000, 0, 0, 3, 0);
    xl("R11 faulted pa zero", 16'ha555, 0, 1, 3, 0);
  endtask

  task automatic t_sets;
    wr_ent(1, 4'h2, ent(8'hc3, 1,1,1,1,1,0,1));
    xl("R9 set0 still used", 16'h2010, 0, 0, 0, 20'h5a010);
    sel(1);
    xl("R9 set1 selected", 16'h2010, 0, 0, 0, 20'hc3010);
    xl("R9 set1 empty page", 16'h3000, 0, 0, 1, 0);
    sel(0);
    xl("R9 back to set0", 16'h2010, 0, 0, 0, 20'h5a010);
  endtask

  task automatic t_collide;
    wr_ent(0, 4'h5, ent(8'ha1, 1,1,1,1,1,0,1));
    @(negedge clk);
    req_valid = 1; req_va = 16'h5020; req_acc = 0; req_kmode = 0;
    tbl_we = 1; tbl_set = 0; tbl_vpn = 4'h5; tbl_data = ent(8'hb2, 1,1,1,1,1,0,1);
    @(negedge clk); req_valid = 0; tbl_we = 0;
    chk("R10 accepted sees old", rsp_pa, 20'ha1020);
    @(negedge clk);
    xl("R10 write dropped", 16'h5020, 0, 0, 0, 20'ha1020);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_ok();
        t_single_faults();
        t_priority();
        t_sets();
        t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule